// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block is a clocked multiply-accumulate datapath. Each cycle it multiplies two operands and adds the product to a running total, or subtracts the product from it. The signedness of each operand is chosen at run time. A feedback code can replace the running total with zero, so that a new accumulation starts from the product alone. The result goes through an optional saturation stage before it reaches the accumulator. The output then takes either the stored total or the combinational sum that is about to be stored. A final stage can apply a rounded arithmetic right shift.

By default the operands are 20 and 18 bits wide and the result is 38 bits wide. The parameters also give the narrower 10 x 9 -> 19 configuration. An optional staging register on the operands moves the multiplier input one cycle later, to ease timing at the input side.

Top module: `mac_unit`

## Requirements
- R1: An operand whose unsigned flag (`a_uns`, `b_uns`) is 1 is zero-extended. When the flag is 0, the operand is read as two's-complement and sign-extended. The flags always apply to the operand that reaches the multiplier in the current cycle.
- R2: When `sub_en` is 1, the new sum is the feedback term minus the product. When `sub_en` is 0, it is the feedback term plus the product.
- R3: The accumulator takes the sum on a rising clock edge only while `acc_load` is 1. Otherwise it keeps its value.
- R4: Driving `rst_n` low clears the accumulator and the operand staging registers at once, without waiting for a clock edge.
- R5: When `fb_sel` is 3'b001, the feedback term is zero, so the next value is the product, or the negated product when `sub_en` is 1. Every other `fb_sel` code feeds the accumulator back.
- R6: When `out_sel` is 3'd3, the output path takes the pre-register sum. Every other `out_sel` value selects the accumulator.
- R7: When `sat_en` is 0, the sum wraps modulo 2^Z_W, with the result read as signed.
- R8: When `sat_en` is 1, a sum above the largest signed Z_W-bit value becomes that value, and a sum below the smallest becomes that value. The clamped value is both stored and shown on the pre-register path.
- R9: `z` is the selected value arithmetically shifted right by min(`shr_amt`, Z_W) bits.
- R10: When `rnd_en` is 1 and the effective shift s is nonzero, 2^(s-1) is added to the selected value before the shift. The addition does not overflow.
- R11: When `in_reg_en` is 1, the multiplier uses the operands from the previous clock edge. The staging register captures `op_a` and `op_b` on every edge, whatever the value of `in_reg_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | A_W | First operand |
| op_b | input | B_W | Second operand |
| a_uns | input | 1 | Treat op_a as unsigned |
| b_uns | input | 1 | Treat op_b as unsigned |
| acc_load | input | 1 | Accumulator update enable |
| fb_sel | input | 3 | Feedback code; 3'b001 starts fresh |
| sub_en | input | 1 | Subtract the product instead of adding |
| out_sel | input | 3 | 3'd3 selects the pre-register sum; others select the accumulator |
| sat_en | input | 1 | Clamp on overflow |
| shr_amt | input | SHIFT_W | Right-shift amount |
| rnd_en | input | 1 | Round half-up before the shift |
| in_reg_en | input | 1 | Use staged operands |
| z | output | Z_W | Result |

## Verification
The bench drives the sum past both signed limits. With saturation off the value must wrap, and a design that clamps or sign-extends wrongly shows it at once. With saturation on the value must clamp, and a design that wraps shows a sign flip. It uses the most negative signed operands and all-ones unsigned operands to catch an extension that ignores the flags. It also uses fresh-start codes next to reserved feedback codes, which catches decoding that looks at only one bit. Shifts of 1, 37, 38 and 63 with rounding on a negative total expose rounding constants that are off by one and shifts that fill with zeros. Toggling the staging enable while the operands change catches a stage that captures only while enabled, or one that adds no latency.

// File: rtl/mac_pkg.sv
package mac_pkg;
  // feedback code that replaces the accumulator term with zero
  localparam logic [2:0] FB_FRESH = 3'b001;
  // output select code for the pre-register sum
  localparam logic [2:0] OSEL_PRE = 3'd3;
endpackage

// File: rtl/mac_operand_stage.sv
module mac_operand_stage #(
  parameter int A_W = 20,
  parameter int B_W = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [A_W-1:0]        op_a,
  input  logic [B_W-1:0]        op_b,
  input  logic                  a_uns,
  input  logic                  b_uns,
  input  logic                  in_reg_en,
  output logic signed [A_W:0]   a_ext,
  output logic signed [B_W:0]   b_ext
);
  logic [A_W-1:0] a_q, a_d;
  logic [B_W-1:0] b_q, b_d;
  logic [A_W-1:0] a_sel;
  logic [B_W-1:0] b_sel;

  // staging register captures every edge
  always_comb begin
    a_d = op_a;
    b_d = op_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  always_comb begin
    a_sel = in_reg_en ? a_q : op_a;
    b_sel = in_reg_en ? b_q : op_b;
    a_ext = {(a_uns ? 1'b0 : a_sel[A_W-1]), a_sel};
    b_ext = {(b_uns ? 1'b0 : b_sel[B_W-1]), b_sel};
  end
endmodule

// File: rtl/mac_accum_core.sv
module mac_accum_core
  import mac_pkg::*;
#(
  parameter int A_W = 20,
  parameter int B_W = 18,
  parameter int Z_W = 38
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [A_W:0]   a_ext,
  input  logic signed [B_W:0]   b_ext,
  input  logic                  acc_load,
  input  logic [2:0]            fb_sel,
  input  logic                  sub_en,
  input  logic                  sat_en,
  output logic signed [Z_W-1:0] sum_sat,
  output logic signed [Z_W-1:0] acc_q
);
  localparam int PROD_W = A_W + B_W + 2;
  localparam int SUM_W  = ((PROD_W > Z_W) ? PROD_W : Z_W) + 1;
  localparam logic signed [SUM_W-1:0] MAXV = {{(SUM_W-Z_W+1){1'b0}}, {(Z_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MINV = {{(SUM_W-Z_W+1){1'b1}}, {(Z_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [Z_W-1:0]    fb_term;
  logic signed [SUM_W-1:0]  fb_wide, prod_wide, sum_wide;
  logic signed [Z_W-1:0]    acc_d;

  always_comb begin
    prod      = a_ext * b_ext;
    fb_term   = (fb_sel == FB_FRESH) ? '0 : acc_q;
    fb_wide   = SUM_W'(fb_term);
    prod_wide = SUM_W'(prod);
    sum_wide  = sub_en ? (fb_wide - prod_wide) : (fb_wide + prod_wide);
    if (sat_en && (sum_wide > MAXV))
      sum_sat = {1'b0, {(Z_W-1){1'b1}}};
    else if (sat_en && (sum_wide < MINV))
      sum_sat = {1'b1, {(Z_W-1){1'b0}}};
    else
      sum_sat = sum_wide[Z_W-1:0];
    acc_d = acc_load ? sum_sat : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/mac_output_stage.sv
module mac_output_stage
  import mac_pkg::*;
#(
  parameter int Z_W     = 38,
  parameter int SHIFT_W = 6
) (
  input  logic [2:0]            out_sel,
  input  logic signed [Z_W-1:0] sum_sat,
  input  logic signed [Z_W-1:0] acc_q,
  input  logic [SHIFT_W-1:0]    shr_amt,
  input  logic                  rnd_en,
  output logic [Z_W-1:0]        z
);
  localparam int EXT_W = Z_W + 2;
  localparam logic [SHIFT_W-1:0] SH_CAP = SHIFT_W'(Z_W);

  logic signed [Z_W-1:0]   v;
  logic signed [EXT_W-1:0] v_ext, rnd_term;
  logic [SHIFT_W-1:0]      eff;

  always_comb begin
    v        = (out_sel == OSEL_PRE) ? sum_sat : acc_q;
    v_ext    = {{2{v[Z_W-1]}}, v};
    eff      = (shr_amt > SH_CAP) ? SH_CAP : shr_amt;
    rnd_term = (rnd_en && (eff != '0)) ? (EXT_W'(1) << (eff - SHIFT_W'(1))) : '0;
    z        = Z_W'((v_ext + rnd_term) >>> eff);
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int A_W     = 20,
  parameter int B_W     = 18,
  parameter int Z_W     = 38,
  parameter int SHIFT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [A_W-1:0]     op_a,
  input  logic [B_W-1:0]     op_b,
  input  logic               a_uns,
  input  logic               b_uns,
  input  logic               acc_load,
  input  logic [2:0]         fb_sel,
  input  logic               sub_en,
  input  logic [2:0]         out_sel,
  input  logic               sat_en,
  input  logic [SHIFT_W-1:0] shr_amt,
  input  logic               rnd_en,
  input  logic               in_reg_en,
  output logic [Z_W-1:0]     z
);
  logic signed [A_W:0]   a_ext;
  logic signed [B_W:0]   b_ext;
  logic signed [Z_W-1:0] sum_sat;
  logic signed [Z_W-1:0] acc_q;

  mac_operand_stage #(.A_W(A_W), .B_W(B_W)) u_ops (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .a_uns(a_uns), .b_uns(b_uns), .in_reg_en(in_reg_en),
    .a_ext(a_ext), .b_ext(b_ext)
  );

  mac_accum_core #(.A_W(A_W), .B_W(B_W), .Z_W(Z_W)) u_core (
    .clk(clk), .rst_n(rst_n), .a_ext(a_ext), .b_ext(b_ext),
    .acc_load(acc_load), .fb_sel(fb_sel), .sub_en(sub_en), .sat_en(sat_en),
    .sum_sat(sum_sat), .acc_q(acc_q)
  );

  mac_output_stage #(.Z_W(Z_W), .SHIFT_W(SHIFT_W)) u_out (
    .out_sel(out_sel), .sum_sat(sum_sat), .acc_q(acc_q),
    .shr_amt(shr_amt), .rnd_en(rnd_en), .z(z)
  );
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int Z_W     = 38,
  parameter int SHIFT_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_load,
  input logic [2:0]         out_sel,
  input logic [SHIFT_W-1:0] shr_amt,
  input logic [Z_W-1:0]     z,
  input logic [Z_W-1:0]     acc_q,
  input logic [Z_W-1:0]     sum_sat
);
  // R3: no update without the load enable
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_load |=> acc_q == $past(acc_q));

  // R3: with the load enable the register takes the sum
  a_r3_load_takes_sum: assert property (@(posedge clk) disable iff (!rst_n)
    acc_load |=> acc_q == $past(sum_sat));

  // R4: accumulator is zero while reset is held
  a_r4_reset_clear: assert property (@(posedge clk)
    !rst_n |-> acc_q == '0);

  // R6: pre-register path selected
  a_r6_pre_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel == 3'd3 && shr_amt == '0) |-> z == sum_sat);

  // R6: registered path selected
  a_r6_post_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel != 3'd3 && shr_amt == '0) |-> z == acc_q);
endmodule

bind mac_unit mac_unit_chk #(.Z_W(Z_W), .SHIFT_W(SHIFT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_load(acc_load), .out_sel(out_sel),
  .shr_amt(shr_amt), .z(z), .acc_q(acc_q), .sum_sat(sum_sat)
);

// File: tb/mac_unit_test.sv
`timescale 1ns/1ps
module mac_unit_test;
  localparam int A_W = 20, B_W = 18, Z_W = 38, SHIFT_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [A_W-1:0] op_a;
  logic [B_W-1:0] op_b;
  logic a_uns, b_uns, acc_load, sub_en, sat_en, rnd_en, in_reg_en;
  logic [2:0] fb_sel, out_sel;
  logic [SHIFT_W-1:0] shr_amt;
  logic [Z_W-1:0] z;

  int n_cmp = 0, n_bad = 0;
  longint m_acc;
  logic [A_W-1:0] m_pa;
  logic [B_W-1:0] m_pb;

  always #2.5 clk = ~clk;

  mac_unit uut (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .a_uns(a_uns), .b_uns(b_uns), .acc_load(acc_load), .fb_sel(fb_sel),
    .sub_en(sub_en), .out_sel(out_sel), .sat_en(sat_en), .shr_amt(shr_amt),
    .rnd_en(rnd_en), .in_reg_en(in_reg_en), .z(z));

  function automatic longint sx(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  function automatic longint ext(longint raw, int w, bit uns);
    longint m = (64'sd1 <<< w) - 1;
    return uns ? (raw & m) : sx(raw & m, w);
  endfunction

  function automatic longint model_sum();
    longint ea, eb, p, fb, s, mx, mn;
    ea = ext(longint'(in_reg_en ? m_pa : op_a), A_W, a_uns);
    eb = ext(longint'(in_reg_en ? m_pb : op_b), B_W, b_uns);
    p  = ea * eb;
    fb = (fb_sel == 3'b001) ? 0 : m_acc;
    s  = sub_en ? fb - p : fb + p;
    mx = (64'sd1 <<< (Z_W - 1)) - 1;
    mn = -(64'sd1 <<< (Z_W - 1));
    if (sat_en && s > mx) return mx;
    if (sat_en && s < mn) return mn;
    return sx(s, Z_W);
  endfunction

  function automatic longint model_z(longint sum);
    longint v, t;
    int e;
    v = (out_sel == 3'd3) ? sum : m_acc;
    e = (int'(shr_amt) > Z_W) ? Z_W : int'(shr_amt);
    t = (rnd_en && e != 0) ? (64'sd1 <<< (e - 1)) : 0;
    return sx((v + t) >>> e, Z_W);
  endfunction

  task automatic check(string req, longint exp);
    logic [Z_W-1:0] e;
    e = exp[Z_W-1:0];
    n_cmp++;
    if (z !== e) begin
      n_bad++;
      $display("FAIL %s: z=%h expected=%h", req, z, e);
    end
  endtask

  // called just after a negedge with inputs set; checks and advances one cycle
  task automatic step(string req);
    longint s;
    #1;
    s = model_sum();
    check(req, model_z(s));
    @(posedge clk);
    if (acc_load) m_acc = s;
    m_pa = op_a;
    m_pb = op_b;
    @(negedge clk);
  endtask

  task automatic set_in(logic [A_W-1:0] a, logic [B_W-1:0] b, bit au, bit bu,
                        bit ld, logic [2:0] fb, bit sb, logic [2:0] os,
                        bit st, logic [SHIFT_W-1:0] sh, bit rn, bit ir);
    op_a = a; op_b = b; a_uns = au; b_uns = bu; acc_load = ld; fb_sel = fb;
    sub_en = sb; out_sel = os; sat_en = st; shr_amt = sh; rnd_en = rn; in_reg_en = ir;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    set_in(0, 0, 0, 0, 0, 0, 0, 3'd1, 0, 0, 0, 0);
    rst_n = 1'b0;
    m_acc = 0; m_pa = '0; m_pb = '0;
    repeat (3) @(negedge clk);
    step("R4 reset state");
    rst_n = 1'b1;
    @(negedge clk);

    // R5 fresh start from the product
    set_in(20'd3, 18'd5, 0, 0, 1, 3'b001, 0, 3'd3, 0, 0, 0, 0); step("R5 fresh");
    // R2 add with signed negative b
    set_in(20'd2, 18'h3FFFC, 0, 0, 1, 3'b000, 0, 3'd3, 0, 0, 0, 0); step("R2 add signed");
    // R1 same pattern read unsigned
    set_in(20'd2, 18'h3FFFC, 0, 1, 1, 3'b000, 0, 3'd3, 0, 0, 0, 0); step("R1 b unsigned");
    set_in(20'h80000, 18'h20000, 0, 0, 1, 3'b000, 0, 3'd3, 0, 0, 0, 0); step("R1 both min signed");
    set_in(20'h80000, 18'h20000, 1, 0, 1, 3'b000, 1, 3'd3, 0, 0, 0, 0); step("R2 subtract");
    // R5 fresh start while subtracting, reserved codes feed back
    set_in(20'd7, 18'd9, 0, 0, 1, 3'b001, 1, 3'd3, 0, 0, 0, 0); step("R5 fresh negated");
    set_in(20'd1, 18'd1, 0, 0, 1, 3'b011, 0, 3'd3, 0, 0, 0, 0); step("R5 reserved 011");
    set_in(20'd1, 18'd1, 0, 0, 1, 3'b101, 0, 3'd3, 0, 0, 0, 0); step("R5 reserved 101");
    // R3 hold
    for (int i = 0; i < 4; i++) begin
      set_in(20'($urandom), 18'($urandom), 0, 0, 0, 3'b000, 0, 3'd1, 0, 0, 0, 0); step("R3 hold");
    end
    // R6 other select codes
    for (int k = 0; k < 8; k++) begin
      set_in(20'd11, 18'd13, 0, 0, 0, 3'b000, 0, 3'(k), 0, 0, 0, 0); step("R6 select code");
    end
    // R8 positive clamp
    set_in(20'hFFFFF, 18'h3FFFF, 1, 1, 1, 3'b001, 0, 3'd3, 1, 0, 0, 0); step("R8 clamp high pre");
    set_in(20'hFFFFF, 18'h3FFFF, 1, 1, 1, 3'b000, 0, 3'd1, 1, 0, 0, 0); step("R8 clamp high stored");
    set_in(20'hFFFFF, 18'h3FFFF, 1, 1, 1, 3'b000, 0, 3'd1, 1, 0, 0, 0); step("R8 clamp high stored");
    // R8 negative clamp
    set_in(20'hFFFFF, 18'h3FFFF, 1, 1, 1, 3'b001, 1, 3'd3, 1, 0, 0, 0); step("R8 clamp low pre");
    set_in(20'hFFFFF, 18'h3FFFF, 1, 1, 1, 3'b000, 1, 3'd1, 1, 0, 0, 0); step("R8 clamp low stored");
    set_in(20'd0, 18'd0, 0, 0, 0, 3'b000, 0, 3'd1, 1, 0, 0, 0); step("R8 clamp low stored");
    // R7 wrap
    set_in(20'hFFFFF, 18'h3FFFF, 1, 1, 1, 3'b001, 0, 3'd3, 0, 0, 0, 0); step("R7 wrap pre");
    for (int i = 0; i < 3; i++) begin
      set_in(20'hFFFFF, 18'h3FFFF, 1, 1, 1, 3'b000, 0, 3'd1, 0, 0, 0, 0); step("R7 wrap stored");
    end
    // R9 / R10 shift and round on a negative total
    set_in(20'hFFFFB, 18'd12345, 0, 1, 1, 3'b001, 0, 3'd3, 0, 0, 0, 0); step("R9 setup");
    for (int k = 0; k < 7; k++) begin
      logic [SHIFT_W-1:0] sh;
      case (k)
        0: sh = 6'd1; 1: sh = 6'd3; 2: sh = 6'd13; 3: sh = 6'd37;
        4: sh = 6'd38; 5: sh = 6'd39; default: sh = 6'd63;
      endcase
      set_in(0, 0, 0, 0, 0, 3'b000, 0, 3'd1, 0, sh, 0, 0); step("R9 shift");
      set_in(0, 0, 0, 0, 0, 3'b000, 0, 3'd1, 0, sh, 1, 0); step("R10 round");
    end
    set_in(20'd3, 18'd1, 0, 0, 1, 3'b001, 0, 3'd3, 0, 6'd1, 1, 0); step("R10 round half");
    set_in(20'h7FFFF, 18'h1FFFF, 0, 0, 1, 3'b001, 0, 3'd3, 0, 6'd2, 1, 0); step("R10 round large");
    // R11 staging latency
    for (int i = 0; i < 8; i++) begin
      set_in(20'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), 1, 3'b001, 0, 3'd3,
             0, 0, 0, 1'(i % 3 != 0));
      step("R11 staged operands");
    end
    // R4 asynchronous reset mid-run
    set_in(20'd100, 18'd100, 0, 0, 1, 3'b001, 0, 3'd1, 0, 0, 0, 0); step("R4 preload");
    set_in(20'd0, 18'd0, 0, 0, 0, 3'b000, 0, 3'd1, 0, 0, 0, 1);
    rst_n = 1'b0;
    m_acc = 0; m_pa = '0; m_pb = '0;
    #1;
    check("R4 async clear", 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step("R4 after reset");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] fb;
      logic [SHIFT_W-1:0] sh;
      fb = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 6 == 0) ? 3'b001 : 3'b000);
      sh = ($urandom % 3 == 0) ? 6'($urandom) : 6'd0;
      set_in(20'($urandom), 18'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom % 4 != 0), fb, 1'($urandom), 3'($urandom), 1'($urandom),
             sh, 1'($urandom), 1'($urandom));
      step("R1 R2 R7 R8 random mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule